// File: doc/BRIEF.md
# Sequential Booth Signed Multiplier

This block multiplies two W-bit two's complement numbers over W clock cycles and returns their full 2W-bit signed product. It scans the multiplier one bit at a time, together with the bit that was examined just before it. A step from 0 to 1 marks the start of a run of ones, and there the multiplicand is subtracted from the upper half of the product. A step from 1 to 0 marks the end of a run, and there the multiplicand is added. When both bits are equal the upper half is left unchanged. After each step the combined upper and lower halves shift right by one place, and the shift copies the sign bit.

A caller drives the two operands and pulses `start` while `busy` is low. `busy` stays high for exactly W cycles. On the cycle that `busy` falls, `done` pulses for one cycle. The product stays on `product` until the next accepted start.

Top module: `booth_seq_mult`

## Requirements
- R1: In any cycle after a clock edge at which `rst_n` was low, `busy` and `done` are 0 and `product` is 0.
- R2: When `start` is high while `busy` is low, `busy` rises at the next edge. It stays high for exactly W cycles. `done` rises at the same edge at which `busy` falls.
- R3: `product` at `done` equals the signed product of `mcand` and `mplier` as they were sampled at the accepted start. Both operands and the product are two's complement numbers.
- R4: The most negative multiplicand (only the MSB set) times the most negative multiplier gives +2^(2W-2). For W=8 this is 16'h4000.
- R5: `start` and operand changes while `busy` is high are ignored. The result and the timing belong to the operation already in progress.
- R6: `done` is high for a single cycle. `product` keeps its value while the block is idle and no start is given.
- R7: `busy` and `done` are never high in the same cycle.
- R8: A multiplier of all ones (-1) gives the negated multiplicand. A zero operand gives a zero product.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Begin a multiplication when idle |
| mcand | input | W | Multiplicand, two's complement |
| mplier | input | W | Multiplier, two's complement |
| busy | output | 1 | Multiplication in progress |
| done | output | 1 | One-cycle pulse: product is valid |
| product | output | 2W | Signed 2W-bit product |

## Verification
The hardest case to reach is the one where the upper half overflows its W-bit range. This happens only when the multiplicand is the most negative value and a subtraction from zero produces +2^(W-1). The bench drives that operand against the most negative multiplier, against all ones, and against alternating patterns, so that subtraction and addition both land next to the range limits. A sweep of about two hundred arithmetic-progression operand pairs covers mixed runs of ones. A directed task re-pulses `start` with different operands during an operation to show that the result stays with the original pair.

// File: rtl/booth_seq_mult.sv
module booth_seq_mult #(
  parameter int W = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [W-1:0]   mcand,
  input  logic [W-1:0]   mplier,
  output logic           busy,
  output logic           done,
  output logic [2*W-1:0] product
);
  localparam int CW = (W > 2) ? $clog2(W) : 1;
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  logic [W:0]    acc;
  logic [W-1:0]  low, mul, x;
  logic          prev;
  logic [CW-1:0] cnt;
  logic [W:0]    xe, acc_op;

  assign xe = {x[W-1], x};

  always_comb begin
    unique case ({mul[0], prev})
      2'b10:   acc_op = acc - xe;
      2'b01:   acc_op = acc + xe;
      default: acc_op = acc;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc  <= '0;
      low  <= '0;
      mul  <= '0;
      x    <= '0;
      prev <= 1'b0;
      cnt  <= '0;
      busy <= 1'b0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          acc  <= '0;
          low  <= '0;
          prev <= 1'b0;
          mul  <= mplier;
          x    <= mcand;
          cnt  <= '0;
          busy <= 1'b1;
        end
      end else begin
        acc  <= {acc_op[W], acc_op[W:1]};
        low  <= {acc_op[0], low[W-1:1]};
        mul  <= {mul[0], mul[W-1:1]};
        prev <= mul[0];
        cnt  <= cnt + 1'b1;
        if (cnt == LAST) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  assign product = {acc[W-1:0], low};
endmodule

// File: rtl/booth_seq_mult_chk.sv
module booth_seq_mult_chk #(
  parameter int W = 8
) (
  input logic           clk,
  input logic           rst_n,
  input logic           start,
  input logic           busy,
  input logic           done,
  input logic [2*W-1:0] product
);
  assert_reset_R1: assert property (@(posedge clk)
    !rst_n |=> (!busy && !done && product == '0));

  assert_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);

  assert_finish_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> $stable(product));

  assert_no_overlap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done));
endmodule

bind booth_seq_mult booth_seq_mult_chk #(.W(W)) i_chk (
  .clk(clk), .rst_n(rst_n), .start(start),
  .busy(busy), .done(done), .product(product)
);

// File: tb/test_booth_seq_mult.sv
module test_booth_seq_mult;
  localparam int W = 8;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           start = 1'b0;
  logic [W-1:0]   mcand = '0, mplier = '0;
  logic           busy, done;
  logic [2*W-1:0] product;

  int checks = 0, fails = 0, cycles = 0;

  always #5 clk = ~clk;

  booth_seq_mult #(.W(W)) i_booth_seq_mult (
    .clk(clk), .rst_n(rst_n), .start(start), .mcand(mcand), .mplier(mplier),
    .busy(busy), .done(done), .product(product)
  );

  always @(negedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++;
      $display("FAIL watchdog: act=%0d cycles exp<=150000", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [2*W-1:0] act,
                     input logic [2*W-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: act=%h exp=%h", req, act, exp);
    end
  endtask

  // R2 R3 R6 R7: one multiply with full timing and hold check
  task automatic run_mult(input logic [W-1:0] a, input logic [W-1:0] b, input string req);
    logic [2*W-1:0] exp;
    exp = $signed(a) * $signed(b);
    @(negedge clk);
    mcand = a; mplier = b; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy && !done, "R2 busy after start", {15'd0, busy}, 1);
    for (int i = 1; i < W; i++) begin
      @(negedge clk);
      chk(busy && !done, "R7 busy no done", {14'd0, busy, done}, 2);
    end
    @(negedge clk);
    chk(done && !busy, "R2 done after W", {14'd0, busy, done}, 1);
    chk(product == exp, req, product, exp);
    @(negedge clk);
    chk(!done, "R6 single pulse", {15'd0, done}, 0);
    chk(product == exp, "R6 hold", product, exp);
  endtask

  task automatic test_reset;
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk(!busy && !done && product == '0, "R1 reset", product, 0);
    rst_n = 1'b1;
  endtask

  task automatic test_extremes;
    run_mult(8'h80, 8'h80, "R4 min*min");
    run_mult(8'h80, 8'h7f, "R3 min*max");
    run_mult(8'h7f, 8'h80, "R3 max*min");
    run_mult(8'h7f, 8'h7f, "R3 max*max");
    run_mult(8'h80, 8'h01, "R3 min*1");
    run_mult(8'h55, 8'haa, "R3 alternating");
    run_mult(8'haa, 8'h55, "R3 alternating swap");
  endtask

  task automatic test_special;
    run_mult(8'h80, 8'hff, "R8 min*-1");
    run_mult(8'h13, 8'hff, "R8 x*-1");
    run_mult(8'hff, 8'hff, "R8 -1*-1");
    run_mult(8'h00, 8'h9c, "R8 zero mcand");
    run_mult(8'h9c, 8'h00, "R8 zero mplier");
  endtask

  task automatic test_sweep;
    for (int i = 0; i < 200; i++)
      run_mult(W'(i * 37 + 5), W'(i * 91 + 3), "R3 sweep");
  endtask

  task automatic test_restart_ignored;
    logic [2*W-1:0] exp;
    exp = $signed(8'hc3) * $signed(8'h27);
    @(negedge clk);
    mcand = 8'hc3; mplier = 8'h27; start = 1'b1;
    @(negedge clk);
    mcand = 8'h11; mplier = 8'h99;
    for (int i = 1; i < W; i++) begin
      @(negedge clk);
      chk(busy, "R5 still busy", {15'd0, busy}, 1);
    end
    start = 1'b0;
    @(negedge clk);
    chk(done && !busy, "R5 timing kept", {14'd0, busy, done}, 1);
    chk(product == exp, "R5 original operands", product, exp);
    repeat (3) @(negedge clk);
    chk(!busy && product == exp, "R6 idle hold", product, exp);
  endtask

  initial begin
    test_reset;
    test_extremes;
    test_special;
    test_restart_ignored;
    test_sweep;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule